// File: doc/BRIEF.md
# Shared Almost-Empty Status Bus Slot Controller

This block decides when one queue device may place its per-queue almost-empty status onto a status bus that several devices share. A flag-mode pin, captured while reset is held, fixes one of two ways of sharing the bus for the whole run.

In polled mode the devices form a ring. A single token travels around the ring, one device per read-clock edge. A device that receives the token on its expansion input at an edge drives the bus for the following cycle. During that cycle it raises a sync output and passes the token on through its expansion output. The device marked first in the chain takes the token by itself on the first active edge after reset. A lone device closes the ring by wiring its expansion output to its own expansion input, and it then keeps the bus every cycle.

In direct mode the ring is idle. A strobe, sampled at a clock edge together with a read-address bus, selects this device when the address equals its identity and deselects it for any other address. The strobe is disregarded while the configuration-busy input is high. Status values come from the queue logic outside this block.

Top module: `sts_bus_share`

## Requirements
- R1: The mode is latched from `mode_pin` while reset is asserted: 1 selects polled mode, 0 selects direct mode. Changing `mode_pin` after reset release has no effect.
- R2: In polled mode with `FIRST_IN_CHAIN`=1, the device drives the bus in the cycle after the first active clock edge following reset release. No token is required for this. After that, it drives the bus only when a token arrives.
- R3: In polled mode, `xin` high at a clock edge puts the device on the bus for the next cycle. During that cycle `bus_data` carries the `q_status` sampled at that edge. `xin` low at an edge takes the device off the bus.
- R4: `sync_out` is high exactly in the cycles in which the device drives the bus in polled mode. It is always low in direct mode.
- R5: `xout` is high exactly in the cycles in which the device drives the bus in polled mode. It is always low in direct mode, where `xin` is ignored.
- R6: A lone polled device whose `xout` feeds its own `xin` stays on the bus on every cycle after its first active edge.
- R7: In direct mode, `strobe`=1 and `cfg_busy`=0 at an edge selects the device when `rd_addr` equals `DEV_ID` and deselects it otherwise. With `strobe`=0 the selection holds. While selected, `bus_data` follows the `q_status` sampled at each edge.
- R8: In direct mode, `strobe` has no effect on the selection at any edge where `cfg_busy` is 1.
- R9: Whenever `bus_oe` is 0, `bus_data` is all zeros.
- R10: While reset is asserted, `bus_oe`, `sync_out` and `xout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_pin | input | 1 | Sharing mode, latched during reset: 1 polled, 0 direct |
| q_status | input | NUM_Q | Almost-empty status of the device's queues |
| xin | input | 1 | Token in from the previous device in the ring |
| xout | output | 1 | Token out to the next device in the ring |
| sync_out | output | 1 | High while this device owns the bus in polled mode |
| strobe | input | 1 | Direct-mode select strobe |
| rd_addr | input | ADDR_W | Direct-mode device address |
| cfg_busy | input | 1 | High while configuration is still in progress |
| bus_data | output | NUM_Q | Status driven onto the shared bus |
| bus_oe | output | 1 | Output enable for `bus_data` (tri-state enable) |

## Verification
Two pairs of events can land on the same clock edge and are worth checking together.

The first pair is a direct-mode strobe arriving while `cfg_busy` is still high. The bench applies a strobe with a matching address and later a mismatching one during configuration. It judges that the selection left over from before is unchanged.

The second pair is a new token arriving while the device already holds one. A single device looped onto itself does this every cycle, and a driven `xin` pattern does it for back-to-back slots. The bench expects ownership to continue with no gap, and `bus_data` to reload from `q_status` on each such edge.

A reference model in the bench tracks the ring and the selection cycle by cycle. Each output is compared with the model on every clock.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_POLLED = 1'b1
  } share_mode_e;
endpackage

// File: rtl/sts_rst_sync.sv
module sts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/sts_token_slot.sv
module sts_token_slot #(
  parameter bit FIRST_IN_CHAIN = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic xin,
  output logic own,
  output logic seed,
  output logic load
);
  logic own_d, seed_d;
  logic own_q, seed_q;

  always_comb begin
    own_d  = own_q;
    seed_d = seed_q;
    if (en) begin
      own_d  = xin | seed_q;
      seed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= 1'b0;
      seed_q <= FIRST_IN_CHAIN;
    end else begin
      own_q  <= own_d;
      seed_q <= seed_d;
    end
  end

  assign own  = own_q;
  assign seed = seed_q;
  assign load = en & own_d;
endmodule

// File: rtl/sts_direct_sel.sv
module sts_direct_sel #(
  parameter int ADDR_W = 3,
  parameter int DEV_ID = 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  logic              strobe,
  input  logic              cfg_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              sel,
  output logic              load
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ID);

  logic sel_d, sel_q, strobe_ok;

  assign strobe_ok = en & strobe & ~cfg_busy;

  always_comb begin
    sel_d = sel_q;
    if (strobe_ok) sel_d = (rd_addr == MY_ADDR);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  assign sel  = sel_q;
  assign load = en & sel_d;
endmodule

// File: rtl/sts_bus_share.sv
module sts_bus_share
  import sts_pkg::*;
#(
  parameter int NUM_Q          = 4,
  parameter int ADDR_W         = 3,
  parameter int DEV_ID         = 1,
  parameter bit FIRST_IN_CHAIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic [NUM_Q-1:0]  q_status,
  input  logic              xin,
  output logic              xout,
  output logic              sync_out,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cfg_busy,
  output logic [NUM_Q-1:0]  bus_data,
  output logic              bus_oe
);
  logic        rst_ni;
  share_mode_e mode_q;
  logic        polled;
  logic        tok_own, tok_seed, tok_load;
  logic        dir_sel, dir_load;
  logic        load;
  logic [NUM_Q-1:0] data_d, data_q;

  sts_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mode_q <= share_mode_e'(mode_pin);
    else         mode_q <= mode_q;
  end

  assign polled = (mode_q == MODE_POLLED);

  sts_token_slot #(.FIRST_IN_CHAIN(FIRST_IN_CHAIN)) u_tok (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (polled),
    .xin    (xin),
    .own    (tok_own),
    .seed   (tok_seed),
    .load   (tok_load)
  );

  sts_direct_sel #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_dir (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .en       (~polled),
    .strobe   (strobe),
    .cfg_busy (cfg_busy),
    .rd_addr  (rd_addr),
    .sel      (dir_sel),
    .load     (dir_load)
  );

  assign load = polled ? tok_load : dir_load;

  always_comb begin
    data_d = data_q;
    if (load) data_d = q_status;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign bus_oe   = polled ? tok_own : dir_sel;
  assign bus_data = bus_oe ? data_q : '0;
  assign sync_out = polled & tok_own;
  assign xout     = polled & tok_own;
endmodule

// File: rtl/sts_bus_share_chk.sv
module sts_bus_share_chk #(
  parameter int NUM_Q = 4
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             polled,
  input logic             seed,
  input logic             xin,
  input logic             xout,
  input logic             sync_out,
  input logic             cfg_busy,
  input logic [NUM_Q-1:0] q_status,
  input logic [NUM_Q-1:0] bus_data,
  input logic             bus_oe
);
  p_mode_fixed_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $stable(polled));

  p_no_token_idle_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (polled && !xin && !seed) |=> !bus_oe);

  p_token_take_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (polled && xin) |=> (bus_oe && bus_data == $past(q_status)));

  p_direct_quiet_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !polled |-> (!xout && !sync_out));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!polled && cfg_busy) |=> $stable(bus_oe));

  p_sync_owner_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    polled |-> (sync_out == bus_oe));
endmodule

bind sts_bus_share sts_bus_share_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .polled   (polled),
  .seed     (tok_seed),
  .xin      (xin),
  .xout     (xout),
  .sync_out (sync_out),
  .cfg_busy (cfg_busy),
  .q_status (q_status),
  .bus_data (bus_data),
  .bus_oe   (bus_oe)
);

// File: tb/sts_bus_share_tb.sv
module sts_bus_share_tb;
  localparam int NQ = 4;
  localparam int AW = 3;
  localparam int MY_ID = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin = 1'b1;
  logic [NQ-1:0] q_status = '0;
  logic xin_drv = 1'b0;
  logic loop_en = 1'b0;
  logic strobe = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic cfg_busy = 1'b0;
  logic xin, xout, sync_out, bus_oe;
  logic [NQ-1:0] bus_data;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit m_run = 1'b0;

  int m_rcnt = 0;
  bit m_pol = 1'b1, m_own = 1'b0, m_seed = 1'b1, m_sel = 1'b0;
  logic [NQ-1:0] m_data = '0;

  always #10 clk = ~clk;

  assign xin = loop_en ? xout : xin_drv;

  sts_bus_share #(.NUM_Q(NQ), .ADDR_W(AW), .DEV_ID(MY_ID), .FIRST_IN_CHAIN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .q_status(q_status),
    .xin(xin), .xout(xout), .sync_out(sync_out), .strobe(strobe),
    .rd_addr(rd_addr), .cfg_busy(cfg_busy), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    bit x, t;
    if (!rst_n) begin
      m_rcnt = 0; m_pol = mode_pin; m_own = 0; m_seed = 1; m_sel = 0; m_data = '0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      x = loop_en ? m_own : xin_drv;
      if (m_pol) begin
        t = x | m_seed;
        m_seed = 0;
        m_own = t;
        if (t) m_data = q_status;
      end else begin
        if (strobe && !cfg_busy) m_sel = (int'(rd_addr) == MY_ID);
        if (m_sel) m_data = q_status;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    bit e_oe, e_tok;
    if (m_run) begin
      e_oe  = m_pol ? m_own : m_sel;
      e_tok = m_pol & m_own;
      check(bus_oe === e_oe, m_pol ? "R3 bus_oe" : "R7 bus_oe", int'(bus_oe), int'(e_oe));
      check(bus_data === (e_oe ? m_data : '0), e_oe ? "R3 R7 bus_data" : "R9 bus_data",
            int'(bus_data), int'(e_oe ? m_data : '0));
      check(sync_out === e_tok, "R4 sync_out", int'(sync_out), int'(e_tok));
      check(xout === e_tok, "R5 xout", int'(xout), int'(e_tok));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic reset_dut(input bit md, input bit lp);
    step();
    rst_n = 1'b0; mode_pin = md; loop_en = lp; xin_drv = 0; strobe = 0; cfg_busy = 0;
    m_run = 1'b1;
    step(); step(); step();
    check(!bus_oe && !sync_out && !xout, "R10 reset outputs", int'({bus_oe, sync_out, xout}), 0);
    rst_n = 1'b1;
    step(); step();
  endtask

  initial begin
    // polled ring with bench-driven token
    q_status = 4'hA;
    reset_dut(1'b1, 1'b0);
    step();
    check(bus_oe === 1'b1, "R2 first in chain", int'(bus_oe), 1);
    check(bus_data === 4'hA, "R2 first data", int'(bus_data), 'hA);
    step();
    check(bus_oe === 1'b0, "R2 idle without token", int'(bus_oe), 0);
    for (int i = 0; i < 60; i++) begin
      q_status = NQ'(i * 7 + 3);
      xin_drv  = (i % 3 == 0) || (i % 5 == 1);
      if (i == 30) mode_pin = 1'b0;
      step();
    end
    xin_drv = 1'b1; q_status = 4'h6;
    step();
    check(sync_out === 1'b1, "R1 mode kept after pin change", int'(sync_out), 1);
    check(bus_data === 4'h6, "R3 captured status", int'(bus_data), 6);
    xin_drv = 1'b0;
    step();
    check(bus_oe === 1'b0, "R3 released", int'(bus_oe), 0);

    // lone device, self loop
    reset_dut(1'b1, 1'b1);
    step();
    for (int i = 0; i < 20; i++) begin
      q_status = NQ'(i);
      step();
      check(bus_oe === 1'b1 && xout === 1'b1, "R6 self loop holds", int'({bus_oe, xout}), 3);
    end

    // direct mode
    reset_dut(1'b0, 1'b0);
    xin_drv = 1'b1;
    cfg_busy = 1'b1; strobe = 1'b1; rd_addr = AW'(MY_ID);
    step(); step();
    check(bus_oe === 1'b0, "R8 strobe ignored while busy", int'(bus_oe), 0);
    check(sync_out === 1'b0 && xout === 1'b0, "R5 direct ring idle", int'({sync_out, xout}), 0);
    cfg_busy = 1'b0; q_status = 4'h9;
    step();
    check(bus_oe === 1'b1, "R7 select on match", int'(bus_oe), 1);
    check(bus_data === 4'h9, "R7 data", int'(bus_data), 9);
    strobe = 1'b0; rd_addr = 3'd2; q_status = 4'h4;
    step(); step();
    check(bus_oe === 1'b1, "R7 hold without strobe", int'(bus_oe), 1);
    check(bus_data === 4'h4, "R7 data follows", int'(bus_data), 4);
    cfg_busy = 1'b1; strobe = 1'b1;
    step(); step();
    check(bus_oe === 1'b1, "R8 deselect ignored while busy", int'(bus_oe), 1);
    cfg_busy = 1'b0;
    step();
    check(bus_oe === 1'b0, "R7 deselect on mismatch", int'(bus_oe), 0);
    check(bus_data === 4'h0, "R9 zero when off", int'(bus_data), 0);
    mode_pin = 1'b1;
    for (int i = 0; i < 60; i++) begin
      strobe   = ($urandom % 3) == 0;
      cfg_busy = ($urandom % 4) == 0;
      rd_addr  = AW'(($urandom % 2) ? MY_ID : $urandom);
      q_status = NQ'($urandom);
      xin_drv  = NQ'($urandom) != 0;
      step();
    end
    check(sync_out === 1'b0, "R1 direct kept after pin change", int'(sync_out), 0);
    finish_run();
  end
endmodule